// File: doc/BRIEF.md
# Serial NAND Feature Register Target

This block models the feature-register side of a serial NAND device as seen from a single-bit SPI bus (mode 0). It watches chip select, serial clock and the input data line, oversampling all three in the system clock domain. It recognises two register transactions: a register write (opcode, register address byte, value byte) and a register read (opcode, register address byte, then the value shifted out). It also recognises three one-byte commands: write-enable, write-disable and device reset.

Three registers are held: a block-protection byte, a configuration byte and a read-only status byte. The status byte carries the write-enable latch together with busy, erase-fail, program-fail and a two-bit ECC outcome. The last four come from side inputs, so a testbench can pose as the array engine. Any transaction cut short by chip select rising leaves every register as it was. The memory array and page traffic are not modelled.

Top module: `nand_feat_target`

## Requirements
- R1: After system reset, reading address 0xA0 returns 0x38, reading 0xB0 returns 0x10 and the write-enable latch (status bit 1) is 0.
- R2: The byte sequence 0x1F, 0xA0, V stores V in the block-protection register, and a later read of 0xA0 returns V.
- R3: A write to address 0xB0 keeps only bits 6, 4 and 0 of the value; the other configuration bits read back as 0.
- R4: The byte sequence 0x0F, A, followed by eight more clocks, returns the register at address A on the output line, most significant bit first. Each bit is valid before the rising clock edge that samples it.
- R5: A read of 0xC0 returns bit 0 busy, bit 1 write-enable latch, bit 2 erase fail, bit 3 program fail, bits 5:4 ECC state and bits 7:6 zero. The side-input values are those present when the address byte completes.
- R6: The one-byte command 0x06 sets the write-enable latch, and 0x04 clears it.
- R7: The one-byte command 0xFF restores block protection to 0x38 and configuration to 0x10, and clears the write-enable latch.
- R8: Register writes to 0xC0 or to any address other than 0xA0 and 0xB0 change nothing. Reads of any address other than 0xA0, 0xB0 and 0xC0 return 0x00.
- R9: If chip select rises before the last byte of a command has received all eight bits, no register and no latch changes.
- R10: An opcode other than 0x1F, 0x0F, 0x06, 0x04 and 0xFF is ignored for the rest of that chip-select window.
- R11: The output line is 0 while chip select is high and during the opcode and address bytes of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial bus |
| rstN | input | 1 | Active-low asynchronous system reset |
| spiSclk | input | 1 | Serial clock; idle low, data sampled on rising edge |
| spiCsN | input | 1 | Active-low chip select |
| spiMosi | input | 1 | Serial data into the block |
| spiMiso | output | 1 | Serial data out of the block |
| sideBusy | input | 1 | Busy flag presented in status bit 0 |
| sideEraseFail | input | 1 | Erase-fail flag presented in status bit 2 |
| sideProgFail | input | 1 | Program-fail flag presented in status bit 3 |
| sideEcc | input | 2 | ECC outcome presented in status bits 5:4 |

## Verification
The assertions assume the serial clock is slow against the system clock: each high or low phase lasts at least four system clocks. This lets the synchroniser produce one clean edge per transition. They also assume chip select changes only while the serial clock is low. The stimulus holds each phase for six system clocks and moves chip select and the side inputs only with the serial clock low. The side inputs change only while chip select is high, so a status read always sees settled flags. Random transactions mix writes to every address class, read-backs, the one-byte commands, unknown opcodes and aborts cut at random bit counts, with directed cases for each status bit and for the configuration mask.

// File: rtl/nand_feat_pkg.sv
package nand_feat_pkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_REG_WRITE = 8'h1F;
  localparam logic [BYTE_W-1:0] OP_REG_READ  = 8'h0F;
  localparam logic [BYTE_W-1:0] OP_WEL_SET   = 8'h06;
  localparam logic [BYTE_W-1:0] OP_WEL_CLR   = 8'h04;
  localparam logic [BYTE_W-1:0] OP_DEV_RESET = 8'hFF;

  localparam logic [BYTE_W-1:0] ADDR_PROTECT = 8'hA0;
  localparam logic [BYTE_W-1:0] ADDR_CONFIG  = 8'hB0;
  localparam logic [BYTE_W-1:0] ADDR_STATUS  = 8'hC0;

  typedef enum logic [2:0] {
    PH_OPCODE,
    PH_ADDR,
    PH_WDATA,
    PH_RDATA,
    PH_SKIP
  } phase_t;

  typedef struct packed {
    logic              welSet;
    logic              welClr;
    logic              devReset;
    logic              regWrite;
    logic              loadRead;
    logic              shiftOut;
    logic              outEnable;
    logic [BYTE_W-1:0] regAddr;
    logic [BYTE_W-1:0] wrData;
  } featCmd_t;

endpackage

// File: rtl/nand_feat_ctrl.sv
module nand_feat_ctrl
  import nand_feat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     spiSclk,
  input  logic     spiCsN,
  input  logic     spiMosi,
  output featCmd_t cmd
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [SYNC_STAGES-1:0] sclkSync, csSync, mosiSync;
  logic sclkQ, csQ, mosiQ, sclkPrev;
  logic riseEdge, fallEdge, byteDone;
  logic [CNT_W-1:0] bitCnt;
  logic [BYTE_W-2:0] shiftIn;
  logic [BYTE_W-1:0] byteNext, addrQ;
  logic isRead;
  phase_t phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      csSync   <= '1;
      mosiSync <= '0;
      sclkPrev <= 1'b0;
    end else begin
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], spiSclk};
      csSync   <= {csSync[SYNC_STAGES-2:0], spiCsN};
      mosiSync <= {mosiSync[SYNC_STAGES-2:0], spiMosi};
      sclkPrev <= sclkSync[SYNC_STAGES-1];
    end
  end

  assign sclkQ    = sclkSync[SYNC_STAGES-1];
  assign csQ      = csSync[SYNC_STAGES-1];
  assign mosiQ    = mosiSync[SYNC_STAGES-1];
  assign riseEdge = sclkQ & ~sclkPrev & ~csQ;
  assign fallEdge = ~sclkQ & sclkPrev & ~csQ;
  assign byteNext = {shiftIn, mosiQ};
  assign byteDone = riseEdge && (bitCnt == LAST_BIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_OPCODE;
      bitCnt  <= '0;
      shiftIn <= '0;
      addrQ   <= '0;
      isRead  <= 1'b0;
    end else if (csQ) begin
      phase   <= PH_OPCODE;
      bitCnt  <= '0;
      isRead  <= 1'b0;
    end else if (riseEdge) begin
      bitCnt  <= bitCnt + 1'b1;
      shiftIn <= {shiftIn[BYTE_W-3:0], mosiQ};
      if (byteDone) begin
        unique case (phase)
          PH_OPCODE: begin
            if (byteNext == OP_REG_READ) begin
              phase  <= PH_ADDR;
              isRead <= 1'b1;
            end else if (byteNext == OP_REG_WRITE) begin
              phase  <= PH_ADDR;
              isRead <= 1'b0;
            end else begin
              phase  <= PH_SKIP;
            end
          end
          PH_ADDR: begin
            addrQ <= byteNext;
            phase <= isRead ? PH_RDATA : PH_WDATA;
          end
          PH_WDATA: phase <= PH_SKIP;
          PH_RDATA: phase <= PH_SKIP;
          default:  phase <= PH_SKIP;
        endcase
      end
    end
  end

  always_comb begin
    cmd = '0;
    cmd.outEnable = (phase == PH_RDATA) && !csQ;
    cmd.shiftOut  = fallEdge && (phase == PH_RDATA) && (bitCnt != '0);
    if (byteDone) begin
      unique case (phase)
        PH_OPCODE: begin
          cmd.welSet   = (byteNext == OP_WEL_SET);
          cmd.welClr   = (byteNext == OP_WEL_CLR);
          cmd.devReset = (byteNext == OP_DEV_RESET);
        end
        PH_ADDR: begin
          cmd.loadRead = isRead;
          cmd.regAddr  = byteNext;
        end
        PH_WDATA: begin
          cmd.regWrite = 1'b1;
          cmd.regAddr  = addrQ;
          cmd.wrData   = byteNext;
        end
        default: ;
      endcase
    end
  end

  // R6 R7 R2 R4: at most one action per completed byte
  assert_single_action_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.welSet, cmd.welClr, cmd.devReset, cmd.regWrite, cmd.loadRead}));

  // R9: deselecting returns the decoder to the opcode phase with an empty bit count
  assert_abort_restarts_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csQ) |=> (phase == PH_OPCODE) && (bitCnt == '0));

  // R10: an unknown opcode never leads to a register write
  assert_skip_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_SKIP) |-> !cmd.regWrite && !cmd.loadRead);

endmodule

// File: rtl/nand_feat_regs.sv
module nand_feat_regs
  import nand_feat_pkg::*;
#(
  parameter logic [BYTE_W-1:0] PROTECT_DEFAULT = 8'h38,
  parameter logic [BYTE_W-1:0] CONFIG_DEFAULT  = 8'h10,
  parameter logic [BYTE_W-1:0] CONFIG_WMASK    = 8'h51
) (
  input  logic     clk,
  input  logic     rstN,
  input  featCmd_t cmd,
  input  logic     sideBusy,
  input  logic     sideEraseFail,
  input  logic     sideProgFail,
  input  logic [1:0] sideEcc,
  output logic     miso
);

  localparam logic [BYTE_W-1:0] CONFIG_RESET = CONFIG_DEFAULT & CONFIG_WMASK;

  logic [BYTE_W-1:0] protectReg, configReg, statusVal, readVal, txShift;
  logic welBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      protectReg <= PROTECT_DEFAULT;
      configReg  <= CONFIG_RESET;
      welBit     <= 1'b0;
    end else if (cmd.devReset) begin
      protectReg <= PROTECT_DEFAULT;
      configReg  <= CONFIG_RESET;
      welBit     <= 1'b0;
    end else begin
      if (cmd.welSet) welBit <= 1'b1;
      if (cmd.welClr) welBit <= 1'b0;
      if (cmd.regWrite) begin
        if (cmd.regAddr == ADDR_PROTECT) protectReg <= cmd.wrData;
        if (cmd.regAddr == ADDR_CONFIG)  configReg  <= cmd.wrData & CONFIG_WMASK;
      end
    end
  end

  assign statusVal = {2'b00, sideEcc, sideProgFail, sideEraseFail, welBit, sideBusy};

  always_comb begin
    unique case (cmd.regAddr)
      ADDR_PROTECT: readVal = protectReg;
      ADDR_CONFIG:  readVal = configReg;
      ADDR_STATUS:  readVal = statusVal;
      default:      readVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (cmd.loadRead) begin
      txShift <= readVal;
    end else if (cmd.shiftOut) begin
      txShift <= {txShift[BYTE_W-2:0], 1'b0};
    end
  end

  assign miso = cmd.outEnable & txShift[BYTE_W-1];

  // R7: the reset command lands the defaults one cycle later
  assert_reset_defaults_R7: assert property (@(posedge clk) disable iff (!rstN)
    cmd.devReset |=> (protectReg == PROTECT_DEFAULT) && (configReg == CONFIG_RESET) && !welBit);

  // R6: the enable command raises the latch
  assert_latch_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    cmd.welSet |=> welBit);

  // R8: a write aimed at the status address leaves the stored registers alone
  assert_status_write_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.regWrite && cmd.regAddr == ADDR_STATUS) |=> $stable(protectReg) && $stable(configReg) && $stable(welBit));

  // R9: without a completed command no stored value moves
  assert_no_change_without_command_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.regWrite || cmd.devReset || cmd.welSet || cmd.welClr)
      |=> $stable(protectReg) && $stable(configReg) && $stable(welBit));

endmodule

// File: rtl/nand_feat_target.sv
module nand_feat_target
  import nand_feat_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] PROTECT_DEFAULT = 8'h38,
  parameter logic [7:0] CONFIG_DEFAULT  = 8'h10,
  parameter logic [7:0] CONFIG_WMASK    = 8'h51
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       spiSclk,
  input  logic       spiCsN,
  input  logic       spiMosi,
  output logic       spiMiso,
  input  logic       sideBusy,
  input  logic       sideEraseFail,
  input  logic       sideProgFail,
  input  logic [1:0] sideEcc
);

  featCmd_t cmd;

  nand_feat_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .spiSclk (spiSclk),
    .spiCsN  (spiCsN),
    .spiMosi (spiMosi),
    .cmd     (cmd)
  );

  nand_feat_regs #(
    .PROTECT_DEFAULT (PROTECT_DEFAULT),
    .CONFIG_DEFAULT  (CONFIG_DEFAULT),
    .CONFIG_WMASK    (CONFIG_WMASK)
  ) u_regs (
    .clk           (clk),
    .rstN          (rstN),
    .cmd           (cmd),
    .sideBusy      (sideBusy),
    .sideEraseFail (sideEraseFail),
    .sideProgFail  (sideProgFail),
    .sideEcc       (sideEcc),
    .miso          (spiMiso)
  );

endmodule

// File: tb/nand_feat_target_test.sv
module nand_feat_target_test;

  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiSclk = 1'b0;
  logic spiCsN = 1'b1;
  logic spiMosi = 1'b0;
  logic spiMiso;
  logic sideBusy = 1'b0, sideEraseFail = 1'b0, sideProgFail = 1'b0;
  logic [1:0] sideEcc = 2'b00;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] mProtect, mConfig;
  logic mWel;

  always #10 clk = ~clk;

  nand_feat_target uut (
    .clk(clk), .rstN(rstN), .spiSclk(spiSclk), .spiCsN(spiCsN),
    .spiMosi(spiMosi), .spiMiso(spiMiso), .sideBusy(sideBusy),
    .sideEraseFail(sideEraseFail), .sideProgFail(sideProgFail), .sideEcc(sideEcc)
  );

  function automatic logic [7:0] expRead(input logic [7:0] addr);
    case (addr)
      8'hA0: return mProtect;
      8'hB0: return mConfig;
      8'hC0: return {2'b00, sideEcc, sideProgFail, sideEraseFail, mWel, sideBusy};
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit isKnownOp(input logic [7:0] op);
    return (op == 8'h1F) || (op == 8'h0F) || (op == 8'h06) || (op == 8'h04) || (op == 8'hFF);
  endfunction

  task automatic checkEq(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%02h expected=%02h", req, got, exp);
    end
  endtask

  task automatic modelReset();
    mProtect = 8'h38;
    mConfig  = 8'h10;
    mWel     = 1'b0;
  endtask

  task automatic selectLow();
    @(negedge clk);
    spiCsN = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic selectHigh();
    repeat (HALF) @(negedge clk);
    spiCsN = 1'b1;
    repeat (HALF + 2) @(negedge clk);
  endtask

  task automatic xferBits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < n; i++) begin
      spiMosi = tx[7-i];
      repeat (HALF) @(negedge clk);
      rx = {rx[6:0], spiMiso};
      spiSclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spiSclk = 1'b0;
    end
  endtask

  task automatic regWrite(input logic [7:0] addr, input logic [7:0] val);
    logic [7:0] rx;
    selectLow();
    xferBits(8'h1F, 8, rx);
    xferBits(addr, 8, rx);
    xferBits(val, 8, rx);
    checkEq("R11 write-phase output", rx, 8'h00);
    selectHigh();
    if (addr == 8'hA0) mProtect = val;
    if (addr == 8'hB0) mConfig  = val & 8'h51;
  endtask

  task automatic regRead(input logic [7:0] addr, output logic [7:0] val);
    logic [7:0] rx;
    selectLow();
    xferBits(8'h0F, 8, rx);
    checkEq("R11 opcode-phase output", rx, 8'h00);
    xferBits(addr, 8, rx);
    checkEq("R11 address-phase output", rx, 8'h00);
    xferBits(8'h00, 8, val);
    selectHigh();
  endtask

  task automatic readCheck(input string req, input logic [7:0] addr);
    logic [7:0] v;
    regRead(addr, v);
    checkEq(req, v, expRead(addr));
  endtask

  task automatic oneByte(input logic [7:0] op);
    logic [7:0] rx;
    selectLow();
    xferBits(op, 8, rx);
    selectHigh();
    if (op == 8'h06) mWel = 1'b1;
    if (op == 8'h04) mWel = 1'b0;
    if (op == 8'hFF) modelReset();
  endtask

  task automatic abortedWrite(input logic [7:0] addr, input logic [7:0] val, input int bits);
    logic [7:0] rx;
    selectLow();
    xferBits(8'h1F, 8, rx);
    xferBits(addr, 8, rx);
    xferBits(val, bits, rx);
    spiMosi = 1'b0;
    selectHigh();
  endtask

  task automatic abortedByte(input logic [7:0] op, input int bits);
    logic [7:0] rx;
    selectLow();
    xferBits(op, bits, rx);
    spiMosi = 1'b0;
    selectHigh();
  endtask

  task automatic randomSide();
    sideBusy      = 1'($urandom_range(0, 1));
    sideEraseFail = 1'($urandom_range(0, 1));
    sideProgFail  = 1'($urandom_range(0, 1));
    sideEcc       = 2'($urandom_range(0, 3));
  endtask

  function automatic logic [7:0] unknownAddr();
    logic [7:0] a;
    do a = 8'($urandom_range(0, 255));
    while (a == 8'hA0 || a == 8'hB0 || a == 8'hC0);
    return a;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired got=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1D5E_ED01));
    modelReset();
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R11: idle output with chip select high
    checks++;
    if (spiMiso !== 1'b0) begin
      errors++;
      $display("FAIL R11 idle output got=%b expected=0", spiMiso);
    end

    // R1: reset defaults
    readCheck("R1 protect default", 8'hA0);
    readCheck("R1 config default", 8'hB0);
    readCheck("R1 status default", 8'hC0);

    // R2 / R4: write then read back, MSB first
    regWrite(8'hA0, 8'h00);
    readCheck("R2 protect unlocked", 8'hA0);
    regWrite(8'hA0, 8'hA5);
    readCheck("R4 protect pattern A5", 8'hA0);

    // R3: configuration mask
    regWrite(8'hB0, 8'hFF);
    readCheck("R3 config mask FF", 8'hB0);
    regWrite(8'hB0, 8'hAE);
    readCheck("R3 config mask AE", 8'hB0);

    // R5: each status field in isolation
    sideBusy = 1'b1;      readCheck("R5 busy bit0", 8'hC0);      sideBusy = 1'b0;
    sideEraseFail = 1'b1; readCheck("R5 erase bit2", 8'hC0);     sideEraseFail = 1'b0;
    sideProgFail = 1'b1;  readCheck("R5 program bit3", 8'hC0);   sideProgFail = 1'b0;
    sideEcc = 2'b10;      readCheck("R5 ecc bits5:4", 8'hC0);    sideEcc = 2'b00;

    // R6: latch set and clear
    oneByte(8'h06);
    readCheck("R6 latch set", 8'hC0);
    oneByte(8'h04);
    readCheck("R6 latch clear", 8'hC0);

    // R8: status and unknown writes ignored, unknown read zero
    oneByte(8'h06);
    regWrite(8'hC0, 8'h00);
    readCheck("R8 status write ignored", 8'hC0);
    regWrite(8'h55, 8'hFF);
    readCheck("R8 protect after stray write", 8'hA0);
    readCheck("R8 config after stray write", 8'hB0);
    readCheck("R8 unknown read", 8'h55);

    // R9: aborts at several points
    abortedWrite(8'hA0, 8'h12, 7);
    readCheck("R9 abort in data byte", 8'hA0);
    abortedWrite(8'hB0, 8'h01, 0);
    readCheck("R9 abort after address", 8'hB0);
    abortedByte(8'hFF, 5);
    readCheck("R9 partial reset command", 8'hA0);
    abortedByte(8'h04, 7);
    readCheck("R9 partial clear command", 8'hC0);

    // R10: unknown opcode then trailing bytes ignored
    begin
      logic [7:0] rx;
      selectLow();
      xferBits(8'h3C, 8, rx);
      xferBits(8'hA0, 8, rx);
      xferBits(8'h77, 8, rx);
      selectHigh();
    end
    readCheck("R10 unknown opcode ignored", 8'hA0);

    // R7: reset command
    oneByte(8'hFF);
    readCheck("R7 protect restored", 8'hA0);
    readCheck("R7 config restored", 8'hB0);
    readCheck("R7 latch cleared", 8'hC0);

    // Random mix against the model
    for (int it = 0; it < 120; it++) begin
      int sel;
      int pick;
      logic [7:0] addr;
      sel = $urandom_range(0, 8);
      case (sel)
        0: regWrite(8'hA0, 8'($urandom_range(0, 255)));
        1: regWrite(8'hB0, 8'($urandom_range(0, 255)));
        2: regWrite(8'hC0, 8'($urandom_range(0, 255)));
        3: regWrite(unknownAddr(), 8'($urandom_range(0, 255)));
        4: oneByte(8'h06);
        5: oneByte(8'h04);
        6: oneByte(8'hFF);
        7: abortedWrite(($urandom_range(0, 1) != 0) ? 8'hA0 : 8'hB0,
                        8'($urandom_range(0, 255)), $urandom_range(0, 7));
        default: begin
          logic [7:0] op;
          do op = 8'($urandom_range(0, 255)); while (isKnownOp(op));
          oneByte(op);
        end
      endcase
      randomSide();
      pick = $urandom_range(0, 3);
      addr = (pick == 0) ? 8'hA0 : (pick == 1) ? 8'hB0 : (pick == 2) ? 8'hC0 : unknownAddr();
      readCheck("R2 R3 R5 R6 R7 R8 R9 R10 random readback", addr);
      sideBusy = 1'b0; sideEraseFail = 1'b0; sideProgFail = 1'b0; sideEcc = 2'b00;
    end

    // R11: after a read completes the output returns low
    checks++;
    if (spiMiso !== 1'b0) begin
      errors++;
      $display("FAIL R11 final idle output got=%b expected=0", spiMiso);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule